// File: doc/BRIEF.md
# Serial Transmitter with Break Sequencing and Flow-Control Insertion

This block serializes bytes as 8N1 frames on a single line. It has a small transmit queue and advances by one bit each time the bit-time strobe `tick_i` pulses. Baud-rate generation is outside the block. A host loads bytes and issues single-cycle command strobes. The commands enable or disable the transmitter, reset it, start or end a line break, send an Xon or Xoff character ahead of the queue, and suspend or resume the draining of the queue.

Disabling the transmitter does not cut a frame off. The block stops accepting bytes and drops its status outputs, but it still sends the frame in progress and every byte already queued. A break waits until the transmitter has nothing left to send, including bytes loaded after the break command. After a stop-break, the line is held high for one full bit time before the next frame starts.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `txd_o` is 1 and both `tx_rdy_o` and `tx_idle_o` are 0.
- R2: After an enable strobe, `tx_rdy_o` is 1 while the queue has room. `tx_idle_o` is 1 while enabled, with the queue empty, no frame or break active and no flow character pending. A byte written while the queue is full is dropped.
- R3: Each frame is one 0 start bit, then eight data bits with the LSB first, then one 1 stop bit. Each bit lasts from one tick to the next. Queued bytes follow one another with no idle bit between frames.
- R4: A disable strobe clears `tx_rdy_o` and `tx_idle_o` on the next cycle. Writes made while disabled are dropped. The frame in progress and all bytes already queued are still sent.
- R5: A start-break strobe issued while the transmitter is disabled has no effect: `txd_o` stays high.
- R6: A break drives `txd_o` to 0. It starts only when no frame is active and the queue is empty, so bytes queued before or after the command are sent first.
- R7: When the transmitter is already empty, the break starts at the first tick after the command, which is within two bit times.
- R8: After a stop-break strobe, `txd_o` returns to 1 at the first tick. It stays 1 for one whole bit time before any frame starts.
- R9: A reset strobe forces `txd_o` to 1 on the next cycle. It discards all queued bytes, any pending break and any pending flow character, and disables the transmitter.
- R10: A send-Xon strobe (byte 0x11) or send-Xoff strobe (byte 0x13), accepted only while enabled, sends that byte as the next frame after the current one ends. This frame goes ahead of queued data and is sent even while the queue is suspended. A later request replaces an unsent earlier one.
- R11: A hold strobe stops the transmitter from starting any frame from the queue. A resume strobe lets queued frames start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per bit time |
| wr_valid_i | input | 1 | Load `wr_data_i` into the queue |
| wr_data_i | input | 8 | Byte to queue |
| cmd_enable_i | input | 1 | Enable the transmitter |
| cmd_disable_i | input | 1 | Disable the transmitter after it drains |
| cmd_reset_i | input | 1 | Reset the transmitter and flush the queue |
| cmd_brk_start_i | input | 1 | Request a line break |
| cmd_brk_stop_i | input | 1 | End or cancel a break |
| cmd_xon_i | input | 1 | Send an Xon byte next |
| cmd_xoff_i | input | 1 | Send an Xoff byte next |
| cmd_hold_i | input | 1 | Suspend the queue (host Xoff) |
| cmd_resume_i | input | 1 | Cancel the suspension |
| txd_o | output | 1 | Serial line, idles high |
| tx_rdy_o | output | 1 | Enabled and the queue has room |
| tx_idle_o | output | 1 | Enabled and nothing left to send |

## Verification
The reference model steps with the design on every clock while the stimulus runs through several phases. Single bytes and back-to-back bursts with mixed bit patterns confirm bit order and that frames join with no gap. A burst larger than the queue confirms that overflow bytes are dropped. Flow-control requests issued mid-frame and during a hold confirm that the inserted byte comes next and that the hold applies only to queued data. Breaks requested with bytes queued, with bytes loaded after the command, from an empty transmitter and while disabled confirm when a break may begin. A disable with bytes queued and a reset during a frame confirm draining on disable and discarding on reset.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;
  localparam logic [DATA_W-1:0] XON_CHAR  = 8'h11;
  localparam logic [DATA_W-1:0] XOFF_CHAR = 8'h13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_BREAK = 2'd2,
    ST_MARK  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign dout_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= din_i;
  end
endmodule

// File: rtl/tx_cmd.sv
module tx_cmd
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cmd_enable_i,
  input  logic              cmd_disable_i,
  input  logic              cmd_brk_start_i,
  input  logic              cmd_brk_stop_i,
  input  logic              cmd_xon_i,
  input  logic              cmd_xoff_i,
  input  logic              cmd_hold_i,
  input  logic              cmd_resume_i,
  input  logic              in_break_i,
  input  logic              flow_take_i,
  input  logic              brk_go_i,
  input  logic              brk_end_i,
  output logic              en_o,
  output logic              hold_o,
  output logic              flow_pend_o,
  output logic [DATA_W-1:0] flow_char_o,
  output logic              brk_pend_o,
  output logic              stop_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      hold_o      <= 1'b0;
      flow_pend_o <= 1'b0;
      flow_char_o <= '0;
      brk_pend_o  <= 1'b0;
      stop_req_o  <= 1'b0;
    end else if (flush_i) begin
      en_o        <= 1'b0;
      hold_o      <= 1'b0;
      flow_pend_o <= 1'b0;
      flow_char_o <= '0;
      brk_pend_o  <= 1'b0;
      stop_req_o  <= 1'b0;
    end else begin
      if (cmd_enable_i)  en_o <= 1'b1;
      if (cmd_disable_i) en_o <= 1'b0;

      if (cmd_hold_i)   hold_o <= 1'b1;
      if (cmd_resume_i) hold_o <= 1'b0;

      // a new request overrides one that was just consumed
      if (flow_take_i) flow_pend_o <= 1'b0;
      if (en_o && cmd_xon_i) begin
        flow_pend_o <= 1'b1;
        flow_char_o <= XON_CHAR;
      end
      if (en_o && cmd_xoff_i) begin
        flow_pend_o <= 1'b1;
        flow_char_o <= XOFF_CHAR;
      end

      if (brk_go_i) brk_pend_o <= 1'b0;
      if (cmd_brk_start_i && en_o && !in_break_i) brk_pend_o <= 1'b1;
      if (cmd_brk_stop_i) brk_pend_o <= 1'b0;

      if (brk_end_i) stop_req_o <= 1'b0;
      if (cmd_brk_stop_i && in_break_i) stop_req_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              tick_i,
  input  logic              flow_pend_i,
  input  logic [DATA_W-1:0] flow_char_i,
  input  logic              hold_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              brk_pend_i,
  input  logic              stop_req_i,
  output logic              pop_o,
  output logic              flow_take_o,
  output logic              brk_go_o,
  output logic              brk_end_o,
  output tx_state_e         state_o,
  output logic              txd_o
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  tx_state_e             st;
  logic [BW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] sr;
  logic                  free, mid_frame;
  logic [DATA_W-1:0]     load_char;

  assign mid_frame = (st == ST_SEND) && (bit_idx != LAST_BIT);
  assign free      = (st == ST_IDLE) || (st == ST_MARK) ||
                     ((st == ST_SEND) && (bit_idx == LAST_BIT));
  assign load_char = flow_take_o ? flow_char_i : fifo_data_i;

  always_comb begin
    pop_o       = 1'b0;
    flow_take_o = 1'b0;
    brk_go_o    = 1'b0;
    brk_end_o   = 1'b0;
    if (tick_i) begin
      if (st == ST_BREAK) begin
        brk_end_o = stop_req_i;
      end else if (free) begin
        if (flow_pend_i)                     flow_take_o = 1'b1;
        else if (!fifo_empty_i && !hold_i)   pop_o       = 1'b1;
        else if (brk_pend_i && fifo_empty_i) brk_go_o    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      bit_idx <= '0;
      sr      <= '1;
    end else if (flush_i) begin
      st      <= ST_IDLE;
      bit_idx <= '0;
      sr      <= '1;
    end else if (tick_i) begin
      if (flow_take_o || pop_o) begin
        st      <= ST_SEND;
        bit_idx <= '0;
        sr      <= {1'b1, load_char, 1'b0};
      end else if (brk_go_o) begin
        st <= ST_BREAK;
      end else if (brk_end_o) begin
        st <= ST_MARK;
      end else if (mid_frame) begin
        sr      <= {1'b1, sr[FRAME_BITS-1:1]};
        bit_idx <= bit_idx + 1'b1;
      end else if (free) begin
        st <= ST_IDLE;
      end
    end
  end

  assign state_o = st;
  assign txd_o   = (st == ST_SEND) ? sr[0] : (st != ST_BREAK);
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmd_enable_i,
  input  logic              cmd_disable_i,
  input  logic              cmd_reset_i,
  input  logic              cmd_brk_start_i,
  input  logic              cmd_brk_stop_i,
  input  logic              cmd_xon_i,
  input  logic              cmd_xoff_i,
  input  logic              cmd_hold_i,
  input  logic              cmd_resume_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_idle_o
);
  logic              en_q, hold_q, flow_pend, brk_pend, stop_req;
  logic [DATA_W-1:0] flow_char, fifo_data;
  logic              fifo_empty, fifo_full;
  logic              pop, flow_take, brk_go, brk_end;
  logic              in_break;
  tx_state_e         state;

  assign in_break = (state == ST_BREAK);

  tx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (cmd_reset_i),
    .push_i  (wr_valid_i & en_q),
    .din_i   (wr_data_i),
    .pop_i   (pop),
    .dout_o  (fifo_data),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  tx_cmd u_cmd (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .flush_i         (cmd_reset_i),
    .cmd_enable_i    (cmd_enable_i),
    .cmd_disable_i   (cmd_disable_i),
    .cmd_brk_start_i (cmd_brk_start_i),
    .cmd_brk_stop_i  (cmd_brk_stop_i),
    .cmd_xon_i       (cmd_xon_i),
    .cmd_xoff_i      (cmd_xoff_i),
    .cmd_hold_i      (cmd_hold_i),
    .cmd_resume_i    (cmd_resume_i),
    .in_break_i      (in_break),
    .flow_take_i     (flow_take),
    .brk_go_i        (brk_go),
    .brk_end_i       (brk_end),
    .en_o            (en_q),
    .hold_o          (hold_q),
    .flow_pend_o     (flow_pend),
    .flow_char_o     (flow_char),
    .brk_pend_o      (brk_pend),
    .stop_req_o      (stop_req)
  );

  tx_shifter u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (cmd_reset_i),
    .tick_i       (tick_i),
    .flow_pend_i  (flow_pend),
    .flow_char_i  (flow_char),
    .hold_i       (hold_q),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .brk_pend_i   (brk_pend),
    .stop_req_i   (stop_req),
    .pop_o        (pop),
    .flow_take_o  (flow_take),
    .brk_go_o     (brk_go),
    .brk_end_o    (brk_end),
    .state_o      (state),
    .txd_o        (txd_o)
  );

  assign tx_rdy_o  = en_q & ~fifo_full;
  assign tx_idle_o = en_q & fifo_empty & ~flow_pend & (state == ST_IDLE);
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_enable_i,
  input logic cmd_disable_i,
  input logic cmd_reset_i,
  input logic txd_o,
  input logic tx_rdy_o,
  input logic tx_idle_o,
  input logic fifo_full,
  input logic fifo_empty,
  input logic in_break,
  input logic brk_pend,
  input logic en_q
);
  a_r2_enable_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_enable_i && !cmd_disable_i && !cmd_reset_i |=> tx_rdy_o || fifo_full);

  a_r3_idle_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> txd_o);

  a_r4_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_disable_i |=> !tx_rdy_o && !tx_idle_o);

  a_r5_break_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_pend) |-> $past(en_q));

  a_r6_break_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_break) |-> $past(fifo_empty) && !txd_o);

  a_r8_break_ends_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_break) |-> txd_o);

  a_r9_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reset_i |=> txd_o && !tx_rdy_o && !tx_idle_o);
endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_enable_i  (cmd_enable_i),
  .cmd_disable_i (cmd_disable_i),
  .cmd_reset_i   (cmd_reset_i),
  .txd_o         (txd_o),
  .tx_rdy_o      (tx_rdy_o),
  .tx_idle_o     (tx_idle_o),
  .fifo_full     (fifo_full),
  .fifo_empty    (fifo_empty),
  .in_break      (in_break),
  .brk_pend      (brk_pend),
  .en_q          (en_q)
);

// File: tb/uart_tx_flow_tb.sv
module uart_tx_flow_tb;
  localparam int DEPTH = 4;
  localparam int TDIV  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic c_en = 0, c_dis = 0, c_rst = 0, c_bs = 0, c_bp = 0;
  logic c_xon = 0, c_xoff = 0, c_hold = 0, c_res = 0;
  logic txd, rdy, idle;

  int n_checks = 0;
  int n_errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  uart_tx_flow #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .cmd_enable_i(c_en), .cmd_disable_i(c_dis), .cmd_reset_i(c_rst),
    .cmd_brk_start_i(c_bs), .cmd_brk_stop_i(c_bp),
    .cmd_xon_i(c_xon), .cmd_xoff_i(c_xoff),
    .cmd_hold_i(c_hold), .cmd_resume_i(c_res),
    .txd_o(txd), .tx_rdy_o(rdy), .tx_idle_o(idle)
  );

  // reference model: 0 idle, 1 frame, 2 break, 3 post-break mark
  byte unsigned m_q[$];
  int m_st, m_bit;
  byte unsigned m_data, m_fc;
  bit m_en, m_hold, m_fp, m_bp, m_stop;

  task automatic m_clear();
    m_q.delete();
    m_st = 0; m_bit = 0; m_data = 0; m_fc = 0;
    m_en = 0; m_hold = 0; m_fp = 0; m_bp = 0; m_stop = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || c_rst) m_clear();
    else begin
      automatic int  st_old = m_st;
      automatic bit  en_old = m_en;
      automatic int  sz = m_q.size();
      automatic bit  take = 0, go = 0, fin = 0;
      automatic bit  free = (m_st == 0) || (m_st == 3) || (m_st == 1 && m_bit == 9);
      if (tick) begin
        if (m_st == 1 && m_bit < 9) m_bit++;
        else if (m_st == 2) begin
          if (m_stop) begin m_st = 3; fin = 1; end
        end else if (free) begin
          if (m_fp) begin take = 1; m_st = 1; m_bit = 0; m_data = m_fc; end
          else if (sz > 0 && !m_hold) begin m_st = 1; m_bit = 0; m_data = m_q.pop_front(); end
          else if (m_bp && sz == 0) begin go = 1; m_st = 2; end
          else m_st = 0;
        end
      end
      if (c_en)  m_en = 1;
      if (c_dis) m_en = 0;
      if (c_hold) m_hold = 1;
      if (c_res)  m_hold = 0;
      if (take) m_fp = 0;
      if (en_old && c_xon)  begin m_fp = 1; m_fc = 8'h11; end
      if (en_old && c_xoff) begin m_fp = 1; m_fc = 8'h13; end
      if (go) m_bp = 0;
      if (c_bs && en_old && st_old != 2) m_bp = 1;
      if (c_bp) m_bp = 0;
      if (fin) m_stop = 0;
      if (c_bp && st_old == 2) m_stop = 1;
      if (wr_valid && en_old && sz < DEPTH) m_q.push_back(wr_data);
    end
  end

  function automatic bit m_txd();
    if (m_st == 1) return (m_bit == 0) ? 1'b0 : (m_bit == 9) ? 1'b1 : m_data[m_bit-1];
    return m_st != 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      automatic int act = {txd, rdy, idle};
      automatic int exp = {m_txd(), m_en && (m_q.size() < DEPTH),
                           m_en && m_q.size() == 0 && m_st == 0 && !m_fp};
      check(act == exp, cur_req, act, exp);
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % TDIV;
      tick = (cnt == 0);
    end
  end

  task automatic wr(input byte unsigned d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: c_en = 1; 1: c_dis = 1; 2: c_rst = 1; 3: c_bs = 1; 4: c_bp = 1;
      5: c_xon = 1; 6: c_xoff = 1; 7: c_hold = 1; default: c_res = 1;
    endcase
    @(negedge clk);
    {c_en, c_dis, c_rst, c_bs, c_bp, c_xon, c_xoff, c_hold, c_res} = '0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    idle_cycles(3);
    cur_req = "R1";
    check(txd == 1 && rdy == 0 && idle == 0, "R1 reset outputs", {txd, rdy, idle}, 3'b100);
    rst_n = 1;
    idle_cycles(5);
    check(txd == 1 && rdy == 0 && idle == 0, "R1 after release", {txd, rdy, idle}, 3'b100);

    cur_req = "R2";
    pulse(0);
    check(rdy == 1 && idle == 1, "R2 enable status", {rdy, idle}, 2'b11);
    for (int i = 0; i < 7; i++) wr(byte'(8'h40 + i));
    idle_cycles(400);

    cur_req = "R3";
    wr(8'hA5); wr(8'h3C); wr(8'hFF); wr(8'h00);
    idle_cycles(200);

    cur_req = "R10";
    wr(8'h81); wr(8'h7E);
    idle_cycles(12);
    pulse(6);
    idle_cycles(30);
    pulse(5);
    idle_cycles(150);

    cur_req = "R11";
    pulse(7);
    wr(8'h55); wr(8'h66);
    idle_cycles(100);
    check(txd == 1, "R11 held line", txd, 1);
    pulse(6);
    idle_cycles(80);
    pulse(8);
    idle_cycles(120);

    cur_req = "R6";
    wr(8'hC3); wr(8'h18);
    pulse(3);
    wr(8'h99);
    idle_cycles(200);
    check(txd == 0, "R6 break after drain", txd, 0);

    cur_req = "R8";
    pulse(4);
    wr(8'h0F);
    idle_cycles(80);

    cur_req = "R7";
    pulse(3);
    idle_cycles(2 * TDIV);
    check(txd == 0, "R7 break within two bits", txd, 0);
    idle_cycles(20);
    pulse(4);
    idle_cycles(20);

    cur_req = "R4";
    wr(8'h12); wr(8'h34); wr(8'h56);
    idle_cycles(6);
    pulse(1);
    check(rdy == 0 && idle == 0, "R4 status cleared", {rdy, idle}, 2'b00);
    wr(8'hEE);
    idle_cycles(160);

    cur_req = "R5";
    pulse(3);
    idle_cycles(40);
    check(txd == 1, "R5 break ignored when disabled", txd, 1);

    cur_req = "R9";
    pulse(0);
    wr(8'hAA); wr(8'hBB); wr(8'hCC);
    idle_cycles(9);
    pulse(2);
    check(txd == 1 && rdy == 0, "R9 reset line", {txd, rdy}, 2'b10);
    idle_cycles(100);
    check(txd == 1, "R9 queue discarded", txd, 1);

    finish_run();
  end
endmodule